// File: doc/BRIEF.md
# Three-wire length-detecting tuner receiver

This block takes tuning commands from a host over a three-wire serial link made of an enable line, a serial clock and a data line. While enable is high, one data bit is taken on every falling edge of the serial clock. When enable drops, the number of bits received decides how the frame is read: 18 and 19 bits carry a band-switch nibble and a frequency word, 27 bits add a control field, and anything shorter only touches the band switches.

All three lines are asynchronous to the fast system clock. They are synchronised first, and edges are detected on the synchronised copies. The block holds the registers that drive a PLL synthesizer: the 15-bit divider word, four band-switch enables, the pump-current select, three test bits, two reference-ratio select bits and the tuning-output disable.

Top module: `tuner_wire_rx`

## Requirements
- R1: The frame length is the number of serial-clock falling edges seen while enable is high. Bits arrive first-to-last in that order, and the frame is classified when enable falls.
- R2: Frame bits 1 to 4 load bandSw, with bit 1 going to bandSw[3] and bit 4 to bandSw[0]. They are committed on the 5th rising serial-clock edge of the frame, before enable falls, whatever the final length.
- R3: An 18-bit frame loads nWord[13:0] from bits 5 to 18, most significant bit first, and clears nWord[14]. It sets ratioA to 1. Both happen when enable falls.
- R4: A 19-bit frame loads nWord[14:0] from bits 5 to 19, most significant bit first, and clears ratioA. Both happen when enable falls, and nWord keeps its old value until then.
- R5: In a frame of 20 or more bits, nWord[14:0] is loaded from bits 5 to 19 on the 20th rising serial-clock edge, before enable falls.
- R6: In a 27-bit frame, bit 20 is a marker and is ignored. When enable falls, bits 21 to 27 load, in this order, cpHigh, testBits[2], testBits[1], testBits[0], ratioA, ratioB and tuneOff.
- R7: cpHigh, testBits, ratioB and tuneOff change only through a 27-bit frame. They keep their values through frames of any other length.
- R8: A frame of fewer than 18 bits leaves nWord and ratioA unchanged. A frame of fewer than 5 rising edges also leaves bandSw unchanged.
- R9: A frame of 20 to 26 bits, or of 28 bits and more, is treated as a 19-bit frame. Its frequency comes from the 20th-edge load, ratioA is cleared when enable falls, and the control field is not touched.
- R10: Reset sets nWord to 0, bandSw to 0, cpHigh to 1, testBits to 001, ratioA to 1, ratioB to the parameter RATIO_B_INIT (default 1) and tuneOff to 1.
- R11: Serial-clock and data activity while enable is low changes no output and does not disturb the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rstN | input | 1 | Active-low synchronous reset |
| enIn | input | 1 | Asynchronous frame enable |
| sclIn | input | 1 | Asynchronous serial clock |
| sdaIn | input | 1 | Asynchronous serial data |
| nWord | output | 15 | Divider word |
| bandSw | output | 4 | Band-switch enables |
| cpHigh | output | 1 | Pump-current select, 1 = high current |
| testBits | output | 3 | Test mode bits |
| ratioA | output | 1 | Reference-ratio select A |
| ratioB | output | 1 | Reference-ratio select B |
| tuneOff | output | 1 | Tuning output disabled when 1 |

## Verification
The bench checks the outputs in the middle of a frame as well as at its end. This shows that the band nibble appears after the 5th rising edge and the 27-bit frequency after the 20th, while an 18- or 19-bit frequency stays hidden until enable falls; a design that committed everything at enable fall, or one edge early, would show the wrong word at those points. Frames of 3, 10, 17, 23 and 30 bits exercise the classification edges. A counter that wraps or mis-compares would load control from a 30-bit frame, or frequency from a 17-bit one. Serial-clock toggling with enable low checks that the bit counters are cleared between frames rather than carrying stale counts.

// File: rtl/tuner_rx_pkg.sv
package tuner_rx_pkg;

  // number of bits in the control field of a long frame
  localparam int CTRL_BITS = 7;

  typedef enum logic [2:0] {
    LEN_SHORT,
    LEN_18,
    LEN_19,
    LEN_27,
    LEN_OTHER
  } len_kind_e;

  typedef struct packed {
    logic      shiftBit;    // take the current data bit
    logic      bandLoad;    // 5th rising edge of the frame
    logic      freqLoadMid; // 20th rising edge of the frame
    logic      frameEnd;    // enable has just fallen
    len_kind_e lenKind;     // classification, valid with frameEnd
  } strobe_t;

endpackage

// File: rtl/tw_sync.sv
module tw_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] stage [STAGES];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < STAGES; i++) stage[i] <= '0;
    end else begin
      stage[0] <= asyncIn;
      for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
    end
  end

  assign syncOut = stage[STAGES-1];

endmodule

// File: rtl/tw_ctrl.sv
module tw_ctrl
  import tuner_rx_pkg::*;
#(
  parameter int CNT_W     = 5,
  parameter int BAND_BITS = 4,
  parameter int N_BITS    = 15
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    enNow,
  input  logic    sclNow,
  output strobe_t strobe
);

  localparam int LEN_A    = BAND_BITS + N_BITS - 1;      // 18
  localparam int LEN_B    = BAND_BITS + N_BITS;          // 19
  localparam int LEN_C    = LEN_B + 1 + CTRL_BITS;       // 27
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             enPrev, sclPrev;
  logic [CNT_W-1:0] fallCnt, riseCnt;
  logic             sclRise, sclFall, enFall;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enPrev  <= 1'b0;
      sclPrev <= 1'b0;
    end else begin
      enPrev  <= enNow;
      sclPrev <= sclNow;
    end
  end

  assign sclRise = sclNow & ~sclPrev;
  assign sclFall = ~sclNow & sclPrev;
  assign enFall  = ~enNow & enPrev;

  // bit and edge counters, cleared while enable is low, saturating
  always_ff @(posedge clk) begin
    if (!rstN) begin
      fallCnt <= '0;
      riseCnt <= '0;
    end else if (!enNow) begin
      if (!enFall) begin
        fallCnt <= '0;
        riseCnt <= '0;
      end
    end else begin
      if (sclFall && fallCnt != CNT_MAX) fallCnt <= fallCnt + 1'b1;
      if (sclRise && riseCnt != CNT_MAX) riseCnt <= riseCnt + 1'b1;
    end
  end

  len_kind_e kindNow;
  always_comb begin
    if (fallCnt < CNT_W'(LEN_A))       kindNow = LEN_SHORT;
    else if (fallCnt == CNT_W'(LEN_A)) kindNow = LEN_18;
    else if (fallCnt == CNT_W'(LEN_B)) kindNow = LEN_19;
    else if (fallCnt == CNT_W'(LEN_C)) kindNow = LEN_27;
    else                               kindNow = LEN_OTHER;
  end

  always_comb begin
    strobe.shiftBit    = enNow & sclFall;
    strobe.bandLoad    = enNow & sclRise & (riseCnt == CNT_W'(BAND_BITS));
    strobe.freqLoadMid = enNow & sclRise & (riseCnt == CNT_W'(LEN_B));
    strobe.frameEnd    = enFall;
    strobe.lenKind     = kindNow;
  end

  // R1: the bit count never wraps back to zero inside a frame
  assert_cnt_no_wrap_R1: assert property (@(posedge clk) disable iff (!rstN)
    (enNow && fallCnt != '0) |=> (fallCnt != '0));

  // R5: the 20th rising edge always follows exactly 19 captured bits
  assert_mid_after_19_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.freqLoadMid |-> (fallCnt == CNT_W'(LEN_B)));

  // R11: no load strobe fires while enable is low
  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rstN)
    (!enNow && !enPrev) |-> !(strobe.bandLoad || strobe.freqLoadMid || strobe.frameEnd));

endmodule

// File: rtl/tw_dpath.sv
module tw_dpath
  import tuner_rx_pkg::*;
#(
  parameter int   N_BITS       = 15,
  parameter int   BAND_BITS    = 4,
  parameter logic RATIO_B_INIT = 1'b1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  strobe_t              strobe,
  input  logic                 dataBit,
  output logic [N_BITS-1:0]    nWord,
  output logic [BAND_BITS-1:0] bandSw,
  output logic                 cpHigh,
  output logic [2:0]           testBits,
  output logic                 ratioA,
  output logic                 ratioB,
  output logic                 tuneOff
);

  logic [N_BITS-1:0] shiftReg;

  always_ff @(posedge clk) begin
    if (!rstN) shiftReg <= '0;
    else if (strobe.shiftBit) shiftReg <= {shiftReg[N_BITS-2:0], dataBit};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      nWord    <= '0;
      bandSw   <= '0;
      cpHigh   <= 1'b1;
      testBits <= 3'b001;
      ratioA   <= 1'b1;
      ratioB   <= RATIO_B_INIT;
      tuneOff  <= 1'b1;
    end else begin
      if (strobe.bandLoad)    bandSw <= shiftReg[BAND_BITS-1:0];
      if (strobe.freqLoadMid) nWord  <= shiftReg;
      if (strobe.frameEnd) begin
        unique case (strobe.lenKind)
          LEN_18: begin
            nWord  <= {1'b0, shiftReg[N_BITS-2:0]};
            ratioA <= 1'b1;
          end
          LEN_19: begin
            nWord  <= shiftReg;
            ratioA <= 1'b0;
          end
          LEN_OTHER: ratioA <= 1'b0;
          LEN_27: begin
            cpHigh   <= shiftReg[6];
            testBits <= shiftReg[5:3];
            ratioA   <= shiftReg[2];
            ratioB   <= shiftReg[1];
            tuneOff  <= shiftReg[0];
          end
          default: ;
        endcase
      end
    end
  end

  // R2: band switches move only on the 5th rising edge strobe
  assert_band_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.bandLoad |=> $stable(bandSw));

  // R7: control field moves only at the end of a 27-bit frame
  assert_ctrl_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.frameEnd && strobe.lenKind == LEN_27) |=> $stable({cpHigh, testBits, ratioB, tuneOff}));

  // R8: short frames keep frequency and ratioA
  assert_short_keep_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.frameEnd && strobe.lenKind == LEN_SHORT) |=> $stable({nWord, ratioA}));

  // R3: an 18-bit frame leaves the top divider bit clear and ratioA set
  assert_len18_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.frameEnd && strobe.lenKind == LEN_18) |=> (!nWord[N_BITS-1] && ratioA));

  // R4 / R9: 19-bit and odd long frames clear ratioA
  assert_len19_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.frameEnd && (strobe.lenKind == LEN_19 || strobe.lenKind == LEN_OTHER)) |=> !ratioA);

endmodule

// File: rtl/tuner_wire_rx.sv
module tuner_wire_rx #(
  parameter logic RATIO_B_INIT = 1'b1,
  parameter int   SYNC_STAGES  = 2,
  parameter int   N_BITS       = 15,
  parameter int   BAND_BITS    = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 enIn,
  input  logic                 sclIn,
  input  logic                 sdaIn,
  output logic [N_BITS-1:0]    nWord,
  output logic [BAND_BITS-1:0] bandSw,
  output logic                 cpHigh,
  output logic [2:0]           testBits,
  output logic                 ratioA,
  output logic                 ratioB,
  output logic                 tuneOff
);
  import tuner_rx_pkg::*;

  localparam int LONG_LEN = BAND_BITS + N_BITS + 1 + CTRL_BITS;
  localparam int CNT_W    = $clog2(LONG_LEN + 2);

  logic    enS, sclS, sdaS;
  strobe_t strobe;

  tw_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) uSync (
    .clk    (clk),
    .rstN   (rstN),
    .asyncIn({enIn, sclIn, sdaIn}),
    .syncOut({enS, sclS, sdaS})
  );

  tw_ctrl #(.CNT_W(CNT_W), .BAND_BITS(BAND_BITS), .N_BITS(N_BITS)) uCtrl (
    .clk   (clk),
    .rstN  (rstN),
    .enNow (enS),
    .sclNow(sclS),
    .strobe(strobe)
  );

  tw_dpath #(.N_BITS(N_BITS), .BAND_BITS(BAND_BITS), .RATIO_B_INIT(RATIO_B_INIT)) uDpath (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .dataBit (sdaS),
    .nWord   (nWord),
    .bandSw  (bandSw),
    .cpHigh  (cpHigh),
    .testBits(testBits),
    .ratioA  (ratioA),
    .ratioB  (ratioB),
    .tuneOff (tuneOff)
  );

endmodule

// File: tb/tuner_wire_rx_test.sv
`timescale 1ns/1ps
module tuner_wire_rx_test;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enIn = 1'b0, sclIn = 1'b0, sdaIn = 1'b0;
  logic [14:0] nWord;
  logic [3:0]  bandSw;
  logic        cpHigh, ratioA, ratioB, tuneOff;
  logic [2:0]  testBits;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  tuner_wire_rx uut (
    .clk(clk), .rstN(rstN), .enIn(enIn), .sclIn(sclIn), .sdaIn(sdaIn),
    .nWord(nWord), .bandSw(bandSw), .cpHigh(cpHigh), .testBits(testBits),
    .ratioA(ratioA), .ratioB(ratioB), .tuneOff(tuneOff)
  );

  typedef struct packed {
    logic [5:0]  len;
    logic [26:0] bits;   // first bit of the frame at bit 26
    logic [14:0] expN;
    logic [3:0]  expBand;
    logic [6:0]  expCtl; // {cp, t2, t1, t0, ratioA, ratioB, tuneOff}
  } vec_t;

  localparam int NVEC = 11;
  localparam vec_t VECS [NVEC] = '{
    '{6'd18, {4'b1000, 14'h0A0B, 9'b0},              15'h0A0B, 4'b1000, 7'b1001111},
    '{6'd19, {4'b0100, 15'h5123, 8'b0},              15'h5123, 4'b0100, 7'b1001011},
    '{6'd27, {4'b0001, 15'h1280, 1'b1, 7'b0001000},  15'h1280, 4'b0001, 7'b0001000},
    '{6'd18, {4'b0010, 14'h1FFF, 9'b0},              15'h1FFF, 4'b0010, 7'b0001100},
    '{6'd10, {4'b1111, 6'b101010, 17'b0},            15'h1FFF, 4'b1111, 7'b0001100},
    '{6'd23, {4'b0011, 15'h7ABC, 1'b1, 3'b111, 4'b0}, 15'h7ABC, 4'b0011, 7'b0001000},
    '{6'd27, {4'b0101, 15'h0001, 1'b1, 7'b1110111},  15'h0001, 4'b0101, 7'b1110111},
    '{6'd19, {4'b1001, 15'h4000, 8'b0},              15'h4000, 4'b1001, 7'b1110011},
    '{6'd30, {4'b0110, 15'h2222, 1'b1, 7'b0000000},  15'h2222, 4'b0110, 7'b1110011},
    '{6'd17, {4'b1010, 15'h3333, 8'b0},              15'h2222, 4'b1010, 7'b1110011},
    '{6'd3,  {3'b111, 24'b0},                        15'h2222, 4'b1010, 7'b1110011}
  };

  function automatic logic [6:0] ctlNow();
    return {cpHigh, testBits, ratioA, ratioB, tuneOff};
  endfunction

  function automatic logic bitAt(input logic [26:0] w, input int i);
    return (i < 27) ? w[26-i] : 1'b0;
  endfunction

  function automatic string tagFor(input int len);
    if (len < 18)  return "R8";
    if (len == 18) return "R3";
    if (len == 19) return "R4";
    if (len == 27) return "R6";
    return "R9";
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic riseHalf(input logic b);
    sdaIn = b;
    repeat (4) @(negedge clk);
    sclIn = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic fallHalf();
    sclIn = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic sendRange(input logic [26:0] w, input int first, input int last);
    for (int i = first; i <= last; i++) begin
      riseHalf(bitAt(w, i));
      fallHalf();
    end
  endtask

  task automatic enOn();
    enIn = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic enOff();
    enIn = 1'b0;
    repeat (10) @(negedge clk);
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    repeat (4) @(negedge clk);

    // R10 reset state
    check("R10 nWord", 32'(nWord), 32'h0);
    check("R10 bandSw", 32'(bandSw), 32'h0);
    check("R10 control", 32'(ctlNow()), 32'(7'b1001111));

    // R1 length classification over the vector table
    for (int v = 0; v < NVEC; v++) begin
      enOn();
      sendRange(VECS[v].bits, 0, int'(VECS[v].len) - 1);
      enOff();
      check({"R1 ", tagFor(int'(VECS[v].len)), " nWord"}, 32'(nWord), 32'(VECS[v].expN));
      check({"R1 R2 bandSw"}, 32'(bandSw), 32'(VECS[v].expBand));
      check({"R1 ", (VECS[v].len == 6'd27) ? "R6" : "R7", " control"},
            32'(ctlNow()), 32'(VECS[v].expCtl));
    end

    // R11 activity with enable low
    for (int k = 0; k < 10; k++) begin
      riseHalf(k[0]);
      fallHalf();
    end
    check("R11 nWord", 32'(nWord), 32'h2222);
    check("R11 bandSw", 32'(bandSw), 32'(4'b1010));
    check("R11 control", 32'(ctlNow()), 32'(7'b1110011));

    // R2 / R5 / R6 commit points inside a 27-bit frame
    begin
      logic [26:0] w;
      w = {4'b1100, 15'h0F0F, 1'b1, 7'b0011001};
      enOn();
      sendRange(w, 0, 3);
      riseHalf(bitAt(w, 4));
      check("R2 band after 5th rise", 32'(bandSw), 32'(4'b1100));
      check("R5 nWord before 20th rise", 32'(nWord), 32'h2222);
      fallHalf();
      sendRange(w, 5, 18);
      riseHalf(bitAt(w, 19));
      check("R5 nWord after 20th rise", 32'(nWord), 32'h0F0F);
      check("R6 control before enable falls", 32'(ctlNow()), 32'(7'b1110011));
      fallHalf();
      sendRange(w, 20, 26);
      enOff();
      check("R6 control after enable falls", 32'(ctlNow()), 32'(7'b0011001));
    end

    // R4 19-bit frequency waits for enable to fall
    begin
      logic [26:0] w;
      w = {4'b0111, 15'h1357, 8'b0};
      enOn();
      sendRange(w, 0, 18);
      check("R4 nWord held until enable falls", 32'(nWord), 32'h0F0F);
      enOff();
      check("R4 nWord", 32'(nWord), 32'h1357);
      check("R4 ratioA", 32'(ratioA), 32'h0);
      check("R7 control kept", 32'(ctlNow()) & 32'h7B, 32'(7'b0011001) & 32'h7B);
    end

    // R10 reset after activity
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check("R10 nWord after reset", 32'(nWord), 32'h0);
    check("R10 control after reset", 32'(ctlNow()), 32'(7'b1001111));

    done = 1'b1;
    summary();
    $finish;
  end

endmodule